// File: doc/BRIEF.md
# Random Byte Generator Peripheral

This peripheral delivers one fresh 8-bit random byte per generation period for as long as it is running. It is driven through triggers rather than enable bits. Writing the trigger value to the go register, or raising the hardware start input, arms a cycle-counting period timer. Writing the trigger value to the halt register, or raising the hardware stop input, disarms it. Each time the timer expires, the block does three things: it captures a byte into the data register, it sets a sticky ready flag, and it drives a one-cycle ready pulse that neighbouring logic can use as an event.

The ready flag can drive a level interrupt through an enable bit. That enable bit has three access points: a direct write, a set alias and a clear alias. An auto-halt bit stops the block by itself after each byte. A mode bit selects a slower, filtered generation period. The entropy source here is a free-running 16-bit maximal-length LFSR, which stands in for a physical source.

The register bus is a simple 32-bit one with separate read and write strobes. Every access is a full 32-bit word. Reset is synchronous and active high.

Top module: `randbyte_gen`

## Requirements
- R1: After reset, every readable register returns 0, and both `irq` and `ready_pulse` are low.
- R2: A write of exactly 1 to offset 0x000 starts generation. The first byte is ready PERIOD_FAST cycles after the write edge in fast mode, and each later byte follows one period after the one before. A write of any other value to 0x000 is ignored.
- R3: A write of exactly 1 to offset 0x004 stops generation, so no further bytes are produced. A write of any other value to 0x004 is ignored.
- R4: On each expiry, the data register at 0x508 (bits 7:0) captures the low byte of the LFSR. The ready flag at 0x100 (bit 0) is set, and `ready_pulse` is high for exactly one cycle, in the cycle after the expiry edge. The LFSR uses seed 0xACE1 during reset and then shifts left once per clock cycle. Its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R5: A write of 0 to 0x100 clears the ready flag. A write of any nonzero value to 0x100 leaves the flag unchanged. An expiry in the same cycle as a clear wins, so the flag ends up set.
- R6: When auto-halt (0x200, bit 0) is 1, generation stops in the same cycle that a byte becomes ready. No further byte appears until the block is started again.
- R7: A write to 0x300 loads the interrupt enable from bit 0. A write to 0x304 with bit 0 set sets the enable. A write to 0x308 with bit 0 set clears the enable. A write to either alias with bit 0 clear has no effect. A read of any of the three offsets returns the enable in bit 0.
- R8: `irq` is high exactly when both the enable and the ready flag are set. It changes on the same edge as whichever of the two changes.
- R9: When the mode bit (0x504, bit 0) is 1, the period is PERIOD_SLOW cycles instead of PERIOD_FAST; the defaults are 660 and 167. A change of mode while running applies from the next reload.
- R10: While `hw_start` is high it acts like a go write, and while `hw_stop` is high it acts like a halt write. If both are active in the same cycle, the stop wins.
- R11: Read data appears on `bus_rdata` one cycle after the read strobe. A read of an unmapped offset returns 0. A write to an unmapped offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| hw_start | input | 1 | Hardware start trigger |
| hw_stop | input | 1 | Hardware stop trigger |
| ready_pulse | output | 1 | One-cycle pulse per new byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a mode change that lands in the middle of a run. The slow period must govern the current interval, and the fast period must take over only at the reload after it. The stimulus starts the block in slow mode and waits for the first byte. It then clears the mode bit one cycle later and checks the next two bytes at exact cycle positions, one a slow period later and one a fast period after that. Every captured byte is compared with a model of the LFSR that the bench runs alongside the design from reset.

// File: rtl/randbyte_pkg.sv
package randbyte_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_GO      = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_HALT    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_READY   = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_AUTO    = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_IE      = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_IE_SET  = 12'h304;
  localparam logic [ADDR_W-1:0] OFS_IE_CLR  = 12'h308;
  localparam logic [ADDR_W-1:0] OFS_MODE    = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_DATA    = 12'h508;

  typedef struct packed {
    logic auto_halt;
    logic slow_mode;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/randbyte_lfsr.sv
module randbyte_lfsr #(
  parameter int          LFSR_W = 16,
  parameter int          OUT_W  = 8,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  // taps for x^16 + x^14 + x^13 + x^11 + 1
  assign fb  = state_q[LFSR_W-1] ^ state_q[LFSR_W-3] ^ state_q[LFSR_W-4] ^ state_q[LFSR_W-6];
  assign rnd = state_q[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) state_q <= LFSR_W'(SEED);
    else     state_q <= {state_q[LFSR_W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state_q != '0); // R4
endmodule

// File: rtl/randbyte_timer.sv
module randbyte_timer #(
  parameter int PERIOD_FAST = 167,
  parameter int PERIOD_SLOW = 660
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic halt,
  input  logic slow_mode,
  input  logic auto_halt,
  output logic running,
  output logic fire
);
  localparam int CNT_W = $clog2(PERIOD_SLOW + 1);
  localparam logic [CNT_W-1:0] LOAD_FAST = CNT_W'(PERIOD_FAST - 1);
  localparam logic [CNT_W-1:0] LOAD_SLOW = CNT_W'(PERIOD_SLOW - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = slow_mode ? LOAD_SLOW : LOAD_FAST;
  assign fire     = running && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (halt) begin
      running <= 1'b0;
    end else if (go) begin
      running <= 1'b1;
      cnt_q   <= load_val;
    end else if (fire) begin
      if (auto_halt) running <= 1'b0;
      else           cnt_q   <= load_val;
    end else if (running) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_GO_ARMS: assert property (@(posedge clk) disable iff (rst)
    (go && !halt) |=> running); // R2
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
    halt |=> !running); // R3
  AST_SHORT_HALTS: assert property (@(posedge clk) disable iff (rst)
    (fire && auto_halt && !go && !halt) |=> !running); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD_SLOW); // R9
endmodule

// File: rtl/randbyte_regs.sv
module randbyte_regs
  import randbyte_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_start,
  input  logic              hw_stop,
  input  logic              fire,
  input  logic [7:0]        rnd,
  output logic              go,
  output logic              halt,
  output ctrl_t             ctrl,
  output logic              ready_pulse,
  output logic              irq
);
  logic       evt_q, evt_n;
  logic       ie_n;
  logic [7:0] data_q;
  logic       wr_trig;

  assign wr_trig = bus_wr && (bus_wdata == DATA_W'(1));
  assign go      = (wr_trig && bus_addr == OFS_GO) || hw_start;
  assign halt    = (wr_trig && bus_addr == OFS_HALT) || hw_stop;

  always_comb begin
    evt_n = evt_q;
    if (bus_wr && bus_addr == OFS_READY && bus_wdata == '0) evt_n = 1'b0;
    if (fire) evt_n = 1'b1;
  end

  always_comb begin
    ie_n = ctrl.irq_en;
    if (bus_wr) begin
      if (bus_addr == OFS_IE) ie_n = bus_wdata[0];
      else if (bus_addr == OFS_IE_SET && bus_wdata[0]) ie_n = 1'b1;
      else if (bus_addr == OFS_IE_CLR && bus_wdata[0]) ie_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q          <= 1'b0;
      ctrl           <= '0;
      data_q         <= '0;
      ready_pulse    <= 1'b0;
      irq            <= 1'b0;
    end else begin
      evt_q        <= evt_n;
      ctrl.irq_en  <= ie_n;
      ready_pulse  <= fire;
      irq          <= ie_n & evt_n;
      if (fire) data_q <= rnd;
      if (bus_wr && bus_addr == OFS_AUTO) ctrl.auto_halt <= bus_wdata[0];
      if (bus_wr && bus_addr == OFS_MODE) ctrl.slow_mode <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_READY:                    bus_rdata <= DATA_W'(evt_q);
        OFS_AUTO:                     bus_rdata <= DATA_W'(ctrl.auto_halt);
        OFS_IE, OFS_IE_SET, OFS_IE_CLR: bus_rdata <= DATA_W'(ctrl.irq_en);
        OFS_MODE:                     bus_rdata <= DATA_W'(ctrl.slow_mode);
        OFS_DATA:                     bus_rdata <= DATA_W'(data_q);
        default:                      bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ready_pulse |=> !ready_pulse); // R4
  AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    ready_pulse |-> evt_q); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (evt_q && ctrl.irq_en)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fire && !(bus_wr && bus_addr == OFS_READY)) |=> $stable(evt_q)); // R5
endmodule

// File: rtl/randbyte_gen.sv
module randbyte_gen
  import randbyte_pkg::*;
#(
  parameter int PERIOD_FAST = 167,
  parameter int PERIOD_SLOW = 660
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_start,
  input  logic              hw_stop,
  output logic              ready_pulse,
  output logic              irq
);
  logic       go, halt, running, fire;
  logic [7:0] rnd;
  ctrl_t      ctrl;

  randbyte_lfsr #(.LFSR_W(16), .OUT_W(8), .SEED(16'hACE1)) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  randbyte_timer #(.PERIOD_FAST(PERIOD_FAST), .PERIOD_SLOW(PERIOD_SLOW)) u_timer (
    .clk(clk), .rst(rst), .go(go), .halt(halt),
    .slow_mode(ctrl.slow_mode), .auto_halt(ctrl.auto_halt),
    .running(running), .fire(fire)
  );

  randbyte_regs u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_start(hw_start), .hw_stop(hw_stop), .fire(fire), .rnd(rnd),
    .go(go), .halt(halt), .ctrl(ctrl), .ready_pulse(ready_pulse), .irq(irq)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running |=> !ready_pulse); // R3
endmodule

// File: tb/sim_randbyte_gen.sv
`timescale 1ns/1ps
module sim_randbyte_gen;
  localparam int PF = 167;
  localparam int PS = 660;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        hw_start = 1'b0;
  logic        hw_stop = 1'b0;
  logic        ready_pulse;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [15:0] m_lfsr, m_prev;
  logic [7:0]  exp_byte;
  logic [31:0] rd_val;

  always #4 clk = ~clk;

  randbyte_gen u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_start(hw_start), .hw_stop(hw_stop), .ready_pulse(ready_pulse), .irq(irq)
  );

  // LFSR model from R4
  always @(posedge clk) begin
    m_prev <= m_lfsr;
    if (rst) m_lfsr <= 16'hACE1;
    else     m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // pulse expected low for n-1 negedges, high at the n-th
  task automatic wait_pulse(input string req, input int n);
    int early = 0;
    for (int i = 0; i < n - 1; i++) begin
      @(negedge clk);
      if (ready_pulse) early++;
    end
    chk({req, " no early pulse"}, early, 0);
    @(negedge clk);
    chk({req, " pulse on time"}, {31'b0, ready_pulse}, 1);
    exp_byte = m_prev[7:0];
  endtask

  task automatic wait_quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ready_pulse) seen++;
    end
    chk({req, " quiet"}, seen, 0);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pulse", {31'b0, ready_pulse}, 0);
    rd(12'h100, rd_val); chk("R1 ready", rd_val, 0);
    rd(12'h200, rd_val); chk("R1 auto", rd_val, 0);
    rd(12'h300, rd_val); chk("R1 ie", rd_val, 0);
    rd(12'h504, rd_val); chk("R1 mode", rd_val, 0);
    rd(12'h508, rd_val); chk("R1 data", rd_val, 0);
  endtask

  task automatic t_start_stop;
    logic [7:0] b;
    wr(12'h000, 32'd2);
    wait_quiet("R2 bad go", PF + 5);
    wr(12'h000, 32'd1);
    wait_pulse("R2 first", PF);
    b = exp_byte;
    @(negedge clk);
    chk("R4 pulse width", {31'b0, ready_pulse}, 0);
    rd(12'h508, rd_val); chk("R4 byte", rd_val, {24'b0, b});
    rd(12'h100, rd_val); chk("R4 flag", rd_val, 1);
    wr(12'h004, 32'd5);
    wait_pulse("R3 bad halt / R2 period", PF - 4);
    b = exp_byte;
    rd(12'h508, rd_val); chk("R4 second byte", rd_val, {24'b0, b});
    wr(12'h004, 32'd1);
    wait_quiet("R3 halted", 2 * PF);
  endtask

  task automatic t_flag;
    wr(12'h100, 32'd3);
    rd(12'h100, rd_val); chk("R5 nonzero ignored", rd_val, 1);
    wr(12'h100, 32'd0);
    rd(12'h100, rd_val); chk("R5 cleared", rd_val, 0);
  endtask

  task automatic t_irq;
    wr(12'h000, 32'd1);
    wait_pulse("R8 setup", PF);
    wr(12'h004, 32'd1);
    chk("R8 irq low while disabled", {31'b0, irq}, 0);
    wr(12'h300, 32'd1);
    chk("R8 irq on enable", {31'b0, irq}, 1);
    rd(12'h304, rd_val); chk("R7 read set alias", rd_val, 1);
    wr(12'h308, 32'd2);
    rd(12'h308, rd_val); chk("R7 clr bit0 zero ignored", rd_val, 1);
    wr(12'h308, 32'd1);
    chk("R8 irq off after clr", {31'b0, irq}, 0);
    rd(12'h300, rd_val); chk("R7 cleared", rd_val, 0);
    wr(12'h304, 32'd2);
    rd(12'h300, rd_val); chk("R7 set bit0 zero ignored", rd_val, 0);
    wr(12'h304, 32'd1);
    chk("R8 irq on after set", {31'b0, irq}, 1);
    wr(12'h100, 32'd0);
    chk("R8 irq off with flag", {31'b0, irq}, 0);
    wr(12'h300, 32'd0);
  endtask

  task automatic t_auto;
    wr(12'h200, 32'd1);
    wr(12'h000, 32'd1);
    wait_pulse("R6 one byte", PF);
    wait_quiet("R6 auto halted", 2 * PF);
    rd(12'h100, rd_val); chk("R6 flag kept", rd_val, 1);
    wr(12'h200, 32'd0);
    wr(12'h100, 32'd0);
  endtask

  task automatic t_mode;
    logic [7:0] b;
    wr(12'h504, 32'd1);
    wr(12'h000, 32'd1);
    wait_pulse("R9 slow first", PS);
    wr(12'h504, 32'd0);
    wait_pulse("R9 slow still", PS - 1);
    b = exp_byte;
    rd(12'h508, rd_val); chk("R4 slow byte", rd_val, {24'b0, b});
    wait_pulse("R9 fast after reload", PF - 1);
    wr(12'h004, 32'd1);
  endtask

  task automatic t_hw;
    hw_start = 1'b1;
    @(negedge clk);
    hw_start = 1'b0;
    wait_pulse("R10 hw start", PF);
    hw_stop = 1'b1;
    @(negedge clk);
    hw_stop = 1'b0;
    wait_quiet("R10 hw stop", 2 * PF);
    hw_start = 1'b1; hw_stop = 1'b1;
    @(negedge clk);
    hw_start = 1'b0; hw_stop = 1'b0;
    wait_quiet("R10 stop wins", 2 * PF);
  endtask

  task automatic t_unmapped;
    wr(12'h50C, 32'hFFFF_FFFF);
    wr(12'h104, 32'd1);
    rd(12'h50C, rd_val); chk("R11 unmapped read", rd_val, 0);
    rd(12'h000, rd_val); chk("R11 go reads zero", rd_val, 0);
    rd(12'h504, rd_val); chk("R11 mode untouched", rd_val, 0);
    rd(12'h200, rd_val); chk("R11 auto untouched", rd_val, 0);
    wait_quiet("R11 no start", PF + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start_stop();
    t_flag();
    t_irq();
    t_auto();
    t_mode();
    t_hw();
    t_unmapped();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule